// File: doc/BRIEF.md
# Window-Based Nonuniform Error Quantizer

This block sits between a fine ADC and a digital compensator in a switching converter loop. Each accepted sample of the output-voltage code is classified as lying in a programmable steady-state window around the reference or outside it. A two-state machine, `ST_STEADY` and `ST_TRANSIENT`, records the operating mode. The block then produces a signed error equal to the reference code minus the quantized sample.

In steady state the sample keeps its full fine resolution. In a transient, one of two behaviours applies, chosen by configuration. In the first, the sample is snapped onto a coarse grid whose step is a power of two, and the rounding is always toward the reference. In the second, fine resolution is kept but the sample-enable strobe sent back to the ADC is decimated, so fewer samples are taken while the loop recovers. The reference is a fixed fine level inside the window.

Only two transitions exist. `ST_STEADY` goes to `ST_TRANSIENT` when an accepted code is strictly outside the window. `ST_TRANSIENT` goes to `ST_STEADY` when an accepted code is strictly inside it. A code that sits exactly on a bound leaves the state unchanged, whichever state that is. Both transitions take place only on an accepted sample.

Top module: `nonuniform_err_quant`

## Requirements
- R1: After reset, `mode_transient` is 0, `err_valid` is 0 and `smp_en` is 1. The configuration then holds its defaults: window 496..528, coarse shift 4, decimation 4 and coarse mode (`cfg_rate_mode` = 0).
- R2: In `ST_STEADY`, an accepted code below `lo` or above `hi` moves the state to `ST_TRANSIENT`. A code equal to `lo` or `hi` keeps `ST_STEADY`.
- R3: In `ST_TRANSIENT`, only an accepted code with `lo` < code < `hi` returns the state to `ST_STEADY`. A code equal to a bound keeps `ST_TRANSIENT`.
- R4: When the new state is `ST_STEADY`, or when `cfg_rate_mode` = 1, the error is `REF_CODE - code` at full resolution.
- R5: When the new state is `ST_TRANSIENT` and `cfg_rate_mode` = 0, the code is quantized with step 2^`shift`. A code below `REF_CODE` is rounded up and a code at or above `REF_CODE` is rounded down, and the result is clamped at `REF_CODE` so it never passes it. The error is `REF_CODE` minus that level.
- R6: A sample is accepted when `smp_valid` and `smp_en` are both high at a clock edge. At that same edge, `err_valid`, `err` (11-bit two's complement for the default 10-bit code) and `mode_transient` update. `err_valid` is high for exactly one cycle per accepted sample.
- R7: With `cfg_rate_mode` = 1 in `ST_TRANSIENT`, `smp_en` is high in the first cycle after entry and then once in every `decim` cycles. A `decim` of 0 or 1 gives an enable in every cycle. Otherwise `smp_en` is always high.
- R8: A sample presented while `smp_en` is low is ignored: no `err_valid` is raised and `mode_transient` keeps its value.
- R9: When `cfg_we` is high, all five configuration fields are loaded at that edge. Samples accepted afterwards are classified and quantized with the new values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load configuration fields |
| cfg_lo | input | CODE_W | Window lower bound |
| cfg_hi | input | CODE_W | Window upper bound |
| cfg_shift | input | SHIFT_W | log2 of the coarse step |
| cfg_decim | input | DECIM_W | Transient decimation ratio |
| cfg_rate_mode | input | 1 | 1: decimate in transient, 0: coarsen in transient |
| smp_valid | input | 1 | Sample code valid |
| smp_code | input | CODE_W | Fine ADC code |
| smp_en | output | 1 | Sample-enable strobe toward the ADC |
| mode_transient | output | 1 | 1 in `ST_TRANSIENT` |
| err_valid | output | 1 | Error valid pulse |
| err | output | CODE_W+1 | Signed error, reference minus quantized code |

## Verification
If the mode register or the decimation counter holds a wrong value, the fault shows at the ports within one cycle. A wrong mode appears on `mode_transient` the cycle after the sample that set it. The next error then uses the wrong resolution and its value is off by up to a coarse step. A counter out of phase shifts the `smp_en` pattern, so a sample that should be taken is dropped, or one that should be dropped is taken. That appears as a missing or extra `err_valid` pulse. Bound codes in both states, and codes on each side of the reference, separate the rounding and hysteresis faults.

// File: rtl/eq_pkg.sv
package eq_pkg;
    typedef enum logic {
        ST_STEADY    = 1'b0,
        ST_TRANSIENT = 1'b1
    } eq_mode_e;
endpackage

// File: rtl/eq_cfg_regs.sv
module eq_cfg_regs #(
    parameter int CODE_W    = 10,
    parameter int SHIFT_W   = 4,
    parameter int DECIM_W   = 4,
    parameter int RST_LO    = 496,
    parameter int RST_HI    = 528,
    parameter int RST_SHIFT = 4,
    parameter int RST_DECIM = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we,
    input  logic [CODE_W-1:0]  lo_in,
    input  logic [CODE_W-1:0]  hi_in,
    input  logic [SHIFT_W-1:0] shift_in,
    input  logic [DECIM_W-1:0] decim_in,
    input  logic               rate_in,
    output logic [CODE_W-1:0]  lo_q,
    output logic [CODE_W-1:0]  hi_q,
    output logic [SHIFT_W-1:0] shift_q,
    output logic [DECIM_W-1:0] decim_q,
    output logic               rate_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_q    <= CODE_W'(RST_LO);
            hi_q    <= CODE_W'(RST_HI);
            shift_q <= SHIFT_W'(RST_SHIFT);
            decim_q <= DECIM_W'(RST_DECIM);
            rate_q  <= 1'b0;
        end else if (we) begin
            lo_q    <= lo_in;
            hi_q    <= hi_in;
            shift_q <= shift_in;
            decim_q <= decim_in;
            rate_q  <= rate_in;
        end
    end
endmodule

// File: rtl/eq_mode_fsm.sv
module eq_mode_fsm
    import eq_pkg::*;
#(
    parameter int CODE_W  = 10,
    parameter int DECIM_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_valid,
    input  logic [CODE_W-1:0]  code,
    input  logic [CODE_W-1:0]  lo,
    input  logic [CODE_W-1:0]  hi,
    input  logic               rate_mode,
    input  logic [DECIM_W-1:0] decim,
    output logic               accept,
    output eq_mode_e           state_d,
    output eq_mode_e           state_q,
    output logic               smp_en
);
    localparam int CW = DECIM_W + 1;

    logic [DECIM_W-1:0] cnt_q, cnt_d;
    logic               decimating;
    logic [CW-1:0]      cnt_inc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STEADY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        decimating = (state_q == ST_TRANSIENT) && rate_mode;
        smp_en     = !decimating || (cnt_q == '0);
        accept     = smp_valid && smp_en;
        cnt_inc    = {1'b0, cnt_q} + CW'(1);
        if (decimating)
            cnt_d = (cnt_inc >= {1'b0, decim}) ? '0 : cnt_inc[DECIM_W-1:0];
        else
            cnt_d = '0;
        state_d = state_q;
        unique case (state_q)
            ST_STEADY:
                if (accept && ((code < lo) || (code > hi)))
                    state_d = ST_TRANSIENT;
            ST_TRANSIENT:
                if (accept && (code > lo) && (code < hi))
                    state_d = ST_STEADY;
            default: state_d = ST_STEADY;
        endcase
    end
endmodule

// File: rtl/eq_quantizer.sv
module eq_quantizer #(
    parameter int CODE_W   = 10,
    parameter int SHIFT_W  = 4,
    parameter int REF_CODE = 512
) (
    input  logic [CODE_W-1:0]  code,
    input  logic               coarse,
    input  logic [SHIFT_W-1:0] shift,
    output logic [CODE_W:0]    err
);
    localparam int W = CODE_W + 1;
    localparam logic [W-1:0] REFX = W'(REF_CODE);

    logic [W-1:0] ext, step_m, up, dn, q;

    always_comb begin
        ext    = {1'b0, code};
        step_m = (W'(1) << shift) - W'(1);
        up     = (ext + step_m) & ~step_m;
        dn     = ext & ~step_m;
        if (!coarse)
            q = ext;
        else if (ext < REFX)
            q = (up > REFX) ? REFX : up;
        else
            q = (dn < REFX) ? REFX : dn;
        err = REFX - q;
    end
endmodule

// File: rtl/nonuniform_err_quant.sv
module nonuniform_err_quant
    import eq_pkg::*;
#(
    parameter int CODE_W    = 10,
    parameter int SHIFT_W   = 4,
    parameter int DECIM_W   = 4,
    parameter int REF_CODE  = 512,
    parameter int RST_LO    = 496,
    parameter int RST_HI    = 528,
    parameter int RST_SHIFT = 4,
    parameter int RST_DECIM = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CODE_W-1:0]  cfg_lo,
    input  logic [CODE_W-1:0]  cfg_hi,
    input  logic [SHIFT_W-1:0] cfg_shift,
    input  logic [DECIM_W-1:0] cfg_decim,
    input  logic               cfg_rate_mode,
    input  logic               smp_valid,
    input  logic [CODE_W-1:0]  smp_code,
    output logic               smp_en,
    output logic               mode_transient,
    output logic               err_valid,
    output logic [CODE_W:0]    err
);
    logic [CODE_W-1:0]  lo_q, hi_q;
    logic [SHIFT_W-1:0] shift_q;
    logic [DECIM_W-1:0] decim_q;
    logic               rate_q, accept, coarse;
    eq_mode_e           state_d, state_q;
    logic [CODE_W:0]    err_d;

    eq_cfg_regs #(
        .CODE_W(CODE_W), .SHIFT_W(SHIFT_W), .DECIM_W(DECIM_W),
        .RST_LO(RST_LO), .RST_HI(RST_HI),
        .RST_SHIFT(RST_SHIFT), .RST_DECIM(RST_DECIM)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we),
        .lo_in(cfg_lo), .hi_in(cfg_hi), .shift_in(cfg_shift),
        .decim_in(cfg_decim), .rate_in(cfg_rate_mode),
        .lo_q(lo_q), .hi_q(hi_q), .shift_q(shift_q),
        .decim_q(decim_q), .rate_q(rate_q)
    );

    eq_mode_fsm #(.CODE_W(CODE_W), .DECIM_W(DECIM_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .code(smp_code),
        .lo(lo_q), .hi(hi_q), .rate_mode(rate_q), .decim(decim_q),
        .accept(accept), .state_d(state_d), .state_q(state_q),
        .smp_en(smp_en)
    );

    assign coarse = (state_d == ST_TRANSIENT) && !rate_q;

    eq_quantizer #(.CODE_W(CODE_W), .SHIFT_W(SHIFT_W), .REF_CODE(REF_CODE)) u_q (
        .code(smp_code), .coarse(coarse), .shift(shift_q), .err(err_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_valid <= 1'b0;
            err       <= '0;
        end else begin
            err_valid <= accept;
            if (accept)
                err <= err_d;
        end
    end

    assign mode_transient = (state_q == ST_TRANSIENT);
endmodule

// File: rtl/eq_checker.sv
module eq_checker #(
    parameter int CODE_W   = 10,
    parameter int REF_CODE = 512
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic [CODE_W-1:0] smp_code,
    input logic              smp_en,
    input logic              mode_transient,
    input logic              err_valid,
    input logic [CODE_W:0]   err
);
    // R6: one valid pulse per accepted sample, one clock later
    a_r6_valid_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        err_valid == $past(smp_valid && smp_en));

    // R8: mode holds when nothing is accepted
    a_r8_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(smp_valid && smp_en) |=> $stable(mode_transient));

    // R4: steady result is full resolution
    a_r4_fine_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && !mode_transient) |->
        ($signed(err) == $signed((CODE_W+1)'(REF_CODE)) - $signed({1'b0, $past(smp_code)})));

    // R5: a code below the reference never yields a negative error
    a_r5_no_overshoot_low: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && ($past(smp_code) < CODE_W'(REF_CODE))) |-> !err[CODE_W]);

    // R5: a code above the reference never yields a positive error
    a_r5_no_overshoot_high: assert property (@(posedge clk) disable iff (!rst_n)
        (err_valid && ($past(smp_code) > CODE_W'(REF_CODE))) |-> (err[CODE_W] || err == '0));

    // R7: the strobe is always on in steady state
    a_r7_en_in_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_transient |-> smp_en);
endmodule

bind nonuniform_err_quant eq_checker #(.CODE_W(CODE_W), .REF_CODE(REF_CODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
    .smp_en(smp_en), .mode_transient(mode_transient),
    .err_valid(err_valid), .err(err)
);

// File: tb/test_nonuniform_err_quant.sv
module test_nonuniform_err_quant;
    localparam int CLK_PERIOD = 10;
    localparam int REF = 512;

    logic       clk = 0, rst_n = 0, cfg_we = 0, cfg_rate_mode = 0, smp_valid = 0;
    logic [9:0] cfg_lo = 0, cfg_hi = 0, smp_code = 0;
    logic [3:0] cfg_shift = 0, cfg_decim = 0;
    logic       smp_en, mode_transient, err_valid;
    logic [10:0] err;

    int checks = 0, fails = 0;
    bit running = 0;

    // behavioural model state
    int m_lo, m_hi, m_shift, m_decim, m_rate, m_tr, m_cnt, m_val, m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    nonuniform_err_quant i_nonuniform_err_quant (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .cfg_shift(cfg_shift), .cfg_decim(cfg_decim), .cfg_rate_mode(cfg_rate_mode),
        .smp_valid(smp_valid), .smp_code(smp_code), .smp_en(smp_en),
        .mode_transient(mode_transient), .err_valid(err_valid), .err(err)
    );

    function automatic int model_en();
        return (m_tr != 0 && m_rate != 0) ? (m_cnt == 0) : 1;
    endfunction

    function automatic int quant(int c, int crs, int sh);
        int st, q;
        st = 1 << sh;
        if (crs == 0) q = c;
        else if (c < REF) begin q = ((c + st - 1) / st) * st; if (q > REF) q = REF; end
        else begin q = (c / st) * st; if (q < REF) q = REF; end
        return REF - q;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lo = 496; m_hi = 528; m_shift = 4; m_decim = 4; m_rate = 0;
            m_tr = 0; m_cnt = 0; m_val = 0; m_err = 0;
        end else begin
            int acc, c, ntr;
            c = int'(smp_code);
            acc = (smp_valid && model_en() != 0) ? 1 : 0;
            ntr = m_tr;
            if (acc != 0) begin
                if (m_tr == 0 && (c < m_lo || c > m_hi)) ntr = 1;
                if (m_tr != 0 && c > m_lo && c < m_hi) ntr = 0;
                m_err = quant(c, (ntr != 0 && m_rate == 0) ? 1 : 0, m_shift);
            end
            m_val = acc;
            if (m_tr != 0 && m_rate != 0) m_cnt = (m_cnt + 1 >= m_decim) ? 0 : m_cnt + 1;
            else m_cnt = 0;
            m_tr = ntr;
            if (cfg_we) begin
                m_lo = int'(cfg_lo); m_hi = int'(cfg_hi); m_shift = int'(cfg_shift);
                m_decim = int'(cfg_decim); m_rate = int'(cfg_rate_mode);
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) if (running) begin
        chk("R7 smp_en", int'(smp_en), model_en());
        chk("R2 R3 mode", int'(mode_transient), m_tr);
        chk("R6 err_valid", int'(err_valid), m_val);
        if (m_val != 0)
            chk((m_tr != 0 && m_rate == 0) ? "R5 coarse err" : "R4 fine err",
                int'($signed(err)), m_err);
    end

    task automatic put(int c);
        @(negedge clk); smp_valid = 1; smp_code = 10'(c);
        @(negedge clk); smp_valid = 0;
    endtask

    task automatic cfg(int lo, int hi, int sh, int dc, int rm);
        @(negedge clk);
        cfg_we = 1; cfg_lo = 10'(lo); cfg_hi = 10'(hi);
        cfg_shift = 4'(sh); cfg_decim = 4'(dc); cfg_rate_mode = rm[0];
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mode", int'(mode_transient), 0);
        chk("R1 err_valid", int'(err_valid), 0);
        chk("R1 smp_en", int'(smp_en), 1);
        running = 1;
        // R4 steady fine codes, R2 bound keeps steady
        put(512); put(500); put(527); put(496); put(528);
        chk("R2 bound steady", int'(mode_transient), 0);
        // R5 coarse below and above, R3 bound keeps transient
        put(401); put(496);
        chk("R3 bound transient", int'(mode_transient), 1);
        put(530); put(600); put(513);
        chk("R3 return steady", int'(mode_transient), 0);
        put(1023); put(0); put(511); put(497);
        // R9 new window and rate mode
        cfg(480, 544, 5, 4, 1);
        put(490);
        chk("R9 new window", int'(mode_transient), 0);
        put(470);
        // R7 decimated strobe, R8 ignored samples
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); smp_valid = 1; smp_code = 10'(460 - i);
        end
        @(negedge clk); smp_valid = 0;
        while (smp_en) @(negedge clk);
        smp_valid = 1; smp_code = 10'(520);
        @(negedge clk); smp_valid = 0;
        chk("R8 ignored valid", int'(err_valid), 0);
        chk("R8 ignored mode", int'(mode_transient), 1);
        // R7 decim zero gives every cycle
        cfg(480, 544, 5, 0, 1);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); smp_valid = 1; smp_code = 10'(600 + i);
        end
        @(negedge clk); smp_valid = 0;
        chk("R7 decim0 strobe", int'(smp_en), 1);
        put(520);
        // R5 coarse with larger step after R9 reload
        cfg(480, 544, 6, 2, 0);
        put(100); put(900); put(515);
        repeat (3) @(negedge clk);
        running = 0;
        finish_run();
    end
endmodule